// File: doc/BRIEF.md
# Physical Register Rename Table

This block renames one instruction per cycle for an out-of-order core. A table records, for every architectural (logical) register, which physical register currently holds its value, and a first-in first-out free list records the physical registers that nothing maps. The physical register pool is larger than the logical set. A rename request carries two logical source numbers and one logical destination number. The sources are translated through the table. The destination gets a fresh physical register from the head of the free list. The physical register that the destination displaces is reported so that retirement logic can hand it back later through the release port.

All rename results are combinational from the current state and the request, so they are valid in the cycle of the request. The table and free-list updates take effect at the next rising clock edge. When the free list is empty, the block lowers its ready output and ignores the request. A flush input returns the mapping and the free list to their reset contents.

Top module: `phys_rename_table`

## Requirements
- R1: After reset, logical register i maps to physical register i (8 logical, 16 physical). The free list holds physical registers 8 to 15, which are handed out in ascending order, starting with 8.
- R2: out_psrc1 and out_psrc2 show the current mapping of req_src1 and req_src2 in the same cycle, whether or not the request is accepted.
- R3: An accepted request with a nonzero destination raises out_has_dst, and out_pdst is the physical register at the head of the free list. That register leaves the free list, and req_dst maps to it from the next cycle on.
- R4: For an accepted request with a nonzero destination, out_pold is the physical register that req_dst mapped to before this request.
- R5: A cycle with rel_valid=1 and flush=0 appends rel_preg to the tail of the free list. It is allocated after every register already on the list.
- R6: rename_ready is 1 exactly when the free list is non-empty. While it is 0, a request changes neither the mapping nor the free list, and out_has_dst stays 0.
- R7: A request whose destination is logical register 0 allocates nothing: out_has_dst stays 0 and the free list keeps its head.
- R8: flush=1 restores the R1 state at the next edge. It overrides a request and a release presented in the same cycle.
- R9: A rename and a release in the same cycle both take effect, even when the rename takes the last free entry.
- R10: An instruction that reads and writes the same logical register reads the mapping that stood before its own destination update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A rename request is presented |
| req_src1 | input | 3 | First logical source register |
| req_src2 | input | 3 | Second logical source register |
| req_dst | input | 3 | Logical destination register; 0 means no destination |
| flush | input | 1 | Restore mapping and free list to reset contents |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | 4 | Physical register being returned |
| rename_ready | output | 1 | Free list non-empty; a request can be accepted |
| out_psrc1 | output | 4 | Physical register for req_src1 |
| out_psrc2 | output | 4 | Physical register for req_src2 |
| out_pdst | output | 4 | Newly allocated physical destination |
| out_pold | output | 4 | Physical register previously mapped to req_dst |
| out_has_dst | output | 1 | A destination was allocated this cycle |

## Verification
Two events can happen in the same cycle: a release that pushes at the tail of the free list, and an allocation that pops at its head. They interact most sharply when only one entry is left. The bench drains the list to one entry, then presents a rename and a release together. It judges the result by whether rename_ready stays high in the next cycle and whether the next allocation returns exactly the released register. A long pseudo-random phase also overlaps renames, releases and occasional flushes, and compares every output against a mapping and queue model kept in the bench.

// File: rtl/rt_pkg.sv
package rt_pkg;
    parameter int unsigned LOG_REGS  = 8;
    parameter int unsigned PHYS_REGS = 16;

    localparam int unsigned LW        = $clog2(LOG_REGS);
    localparam int unsigned PW        = $clog2(PHYS_REGS);
    localparam int unsigned BOOT_FREE = PHYS_REGS - LOG_REGS;

    typedef logic [LW-1:0] lreg_t;
    typedef logic [PW-1:0] preg_t;
    typedef logic [PW:0]   fcount_t;

    typedef struct packed {
        logic  valid;
        lreg_t src1;
        lreg_t src2;
        lreg_t dst;
    } ren_req_t;

    typedef struct packed {
        preg_t psrc1;
        preg_t psrc2;
        preg_t pdst;
        preg_t pold;
        logic  has_dst;
    } ren_rsp_t;

    // Physical register found in free-list slot k right after reset
    function automatic preg_t boot_slot(input int unsigned k);
        return preg_t'(LOG_REGS + k);
    endfunction
endpackage

// File: rtl/rt_map_table.sv
module rt_map_table
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  lreg_t rd_a,
    input  lreg_t rd_b,
    input  lreg_t rd_c,
    output preg_t q_a,
    output preg_t q_b,
    output preg_t q_c,
    input  logic  wr_en,
    input  lreg_t wr_lreg,
    input  preg_t wr_preg
);
    preg_t map_q [LOG_REGS];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < LOG_REGS; i++) begin
                map_q[i] <= preg_t'(i);
            end
        end else if (wr_en) begin
            map_q[wr_lreg] <= wr_preg;
        end
    end

    // Reads see the table before this cycle's write
    assign q_a = map_q[rd_a];
    assign q_b = map_q[rd_b];
    assign q_c = map_q[rd_c];
endmodule

// File: rtl/rt_free_list.sv
module rt_free_list
    import rt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    pop,
    input  logic    push,
    input  preg_t   push_reg,
    output preg_t   head_reg,
    output fcount_t count
);
    localparam int unsigned DEPTH = PHYS_REGS;

    preg_t   slot [DEPTH];
    preg_t   hd_q;
    preg_t   tl_q;
    fcount_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot[k] <= (k < BOOT_FREE) ? boot_slot(k) : preg_t'(0);
            end
            hd_q  <= '0;
            tl_q  <= preg_t'(BOOT_FREE);
            cnt_q <= fcount_t'(BOOT_FREE);
        end else begin
            if (push) begin
                slot[tl_q] <= push_reg;
                tl_q       <= tl_q + 1'b1;
            end
            if (pop) begin
                hd_q <= hd_q + 1'b1;
            end
            cnt_q <= cnt_q + fcount_t'(push) - fcount_t'(pop);
        end
    end

    assign head_reg = slot[hd_q];
    assign count    = cnt_q;
endmodule

// File: rtl/phys_rename_table.sv
module phys_rename_table
    import rt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_src1,
    input  logic [2:0]  req_src2,
    input  logic [2:0]  req_dst,
    input  logic        flush,
    input  logic        rel_valid,
    input  logic [3:0]  rel_preg,
    output logic        rename_ready,
    output logic [3:0]  out_psrc1,
    output logic [3:0]  out_psrc2,
    output logic [3:0]  out_pdst,
    output logic [3:0]  out_pold,
    output logic        out_has_dst
);
    ren_req_t req;
    ren_rsp_t rsp;
    preg_t    fl_head;
    fcount_t  fl_count;
    logic     fl_empty;
    logic     fire;
    logic     alloc;
    logic     do_release;

    assign req.valid = req_valid;
    assign req.src1  = lreg_t'(req_src1);
    assign req.src2  = lreg_t'(req_src2);
    assign req.dst   = lreg_t'(req_dst);

    assign fl_empty   = (fl_count == '0);
    assign fire       = req.valid && !fl_empty && !flush;
    assign alloc      = fire && (req.dst != '0);
    assign do_release = rel_valid && !flush;

    rt_map_table u_map (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .rd_a    (req.src1),
        .rd_b    (req.src2),
        .rd_c    (req.dst),
        .q_a     (rsp.psrc1),
        .q_b     (rsp.psrc2),
        .q_c     (rsp.pold),
        .wr_en   (alloc),
        .wr_lreg (req.dst),
        .wr_preg (fl_head)
    );

    rt_free_list u_free (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .pop      (alloc),
        .push     (do_release),
        .push_reg (preg_t'(rel_preg)),
        .head_reg (fl_head),
        .count    (fl_count)
    );

    assign rsp.pdst    = fl_head;
    assign rsp.has_dst = alloc;

    assign rename_ready = !fl_empty;
    assign out_psrc1    = rsp.psrc1;
    assign out_psrc2    = rsp.psrc2;
    assign out_pdst     = rsp.pdst;
    assign out_pold     = rsp.pold;
    assign out_has_dst  = rsp.has_dst;
endmodule

// File: rtl/rt_checker.sv
module rt_checker
    import rt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       req_valid,
    input logic [2:0] req_src1,
    input logic [2:0] req_dst,
    input logic       rel_valid,
    input logic       rename_ready,
    input logic [3:0] out_psrc1,
    input logic [3:0] out_pdst,
    input logic [3:0] out_pold,
    input logic       out_has_dst,
    input fcount_t    fl_count
);
    // R6: a stalled request leaves the free list untouched
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rename_ready && !rel_valid && !flush) |=> $stable(fl_count));

    // R7: destination 0 does not pop the free list
    a_r7_zero_dst_no_pop: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dst == 3'd0 && !rel_valid && !flush) |=> $stable(fl_count));

    // R3: a fresh register never equals the one it displaces
    a_r3_fresh_differs: assert property (@(posedge clk) disable iff (rst)
        out_has_dst |-> (out_pdst != out_pold));

    // R10: the new mapping is seen by the following instruction
    a_r10_new_map_visible: assert property (@(posedge clk) disable iff (rst)
        out_has_dst |=> (req_src1 != $past(req_dst) || out_psrc1 == $past(out_pdst)));

    // R5: a lone release grows the free list by one
    a_r5_release_grows: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !flush && !out_has_dst) |=> (fl_count == $past(fl_count) + 1'b1));

    // R8: flush brings the free list back to its boot contents
    a_r8_flush_restores: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fl_count == fcount_t'(BOOT_FREE) && rename_ready));

    // R9: the queue never holds more than the physical pool
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        fl_count <= fcount_t'(PHYS_REGS));
endmodule

bind phys_rename_table rt_checker u_chk (.*);

// File: tb/sim_phys_rename_table.sv
`timescale 1ns/1ps
module sim_phys_rename_table;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_src1 = '0, req_src2 = '0, req_dst = '0;
    logic       flush = 1'b0;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_preg = '0;
    logic       rename_ready, out_has_dst;
    logic [3:0] out_psrc1, out_psrc2, out_pdst, out_pold;

    always #2.5 clk = ~clk;

    phys_rename_table u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] m_map [8];
    logic [3:0] m_fq [16];
    int m_hd, m_tl, m_cnt;
    logic [3:0] pend [$];
    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_map[i] = 4'(i);
        for (int k = 0; k < 8; k++) m_fq[k] = 4'(8 + k);
        m_hd = 0; m_tl = 8; m_cnt = 8;
        pend.delete();
    endtask

    task automatic idle();
        req_valid = 0; rel_valid = 0; flush = 0;
    endtask

    // inputs are set at a falling edge; check, then clock the model
    task automatic step();
        logic exp_has;
        #1;
        chk("R6 ready", int'(rename_ready), int'(m_cnt != 0));
        chk("R2 src1", int'(out_psrc1), int'(m_map[req_src1]));
        chk("R2 src2", int'(out_psrc2), int'(m_map[req_src2]));
        exp_has = req_valid && !flush && (m_cnt != 0) && (req_dst != 0);
        chk("R7 has_dst", int'(out_has_dst), int'(exp_has));
        if (exp_has) begin
            chk("R3 pdst", int'(out_pdst), int'(m_fq[m_hd]));
            chk("R4 pold", int'(out_pold), int'(m_map[req_dst]));
        end
        @(posedge clk);
        if (flush) begin
            model_reset();
        end else begin
            if (exp_has) begin
                pend.push_back(m_map[req_dst]);
                m_map[req_dst] = m_fq[m_hd];
                m_hd = (m_hd + 1) % 16; m_cnt--;
            end
            if (rel_valid) begin
                m_fq[m_tl] = rel_preg;
                m_tl = (m_tl + 1) % 16; m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic rename(input int s1, input int s2, input int d);
        req_valid = 1; req_src1 = 3'(s1); req_src2 = 3'(s2); req_dst = 3'(d);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] x, y;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: identity mapping after reset
        for (int i = 0; i < 8; i++) begin
            idle(); req_src1 = 3'(i); req_src2 = 3'(7 - i);
            #1 chk("R1 identity", int'(out_psrc1), i);
            step();
        end

        // R10 and R1: read-write same register, first allocation is 8
        rename(3, 3, 3);
        #1 chk("R10 old source", int'(out_psrc1), 3);
        chk("R1 first alloc", int'(out_pdst), 8);
        step();
        idle(); req_src1 = 3'd3;
        #1 chk("R10 new mapping", int'(out_psrc1), 8);
        step();

        // R7: destination 0 allocates nothing
        rename(1, 2, 0);
        #1 chk("R7 no alloc", int'(out_has_dst), 0);
        step();
        rename(1, 2, 1);
        #1 chk("R7 head kept", int'(out_pdst), 9);
        step();

        // R6: drain and stall
        for (int j = 0; j < 6; j++) begin rename(2, 2, 2); step(); end
        idle();
        #1 chk("R6 empty", int'(rename_ready), 0);
        rename(5, 5, 5);
        step();
        idle(); req_src1 = 3'd5;
        #1 chk("R6 map unchanged", int'(out_psrc1), 5);
        chk("R6 still empty", int'(rename_ready), 0);
        step();

        // R5: release refills, and is allocated next
        x = pend.pop_front();
        idle(); rel_valid = 1; rel_preg = x;
        step();
        idle(); rename(0, 0, 4);
        #1 chk("R5 ready", int'(rename_ready), 1);
        chk("R5 released reused", int'(out_pdst), int'(x));
        idle();
        // R9: one entry left; rename and release together
        x = pend.pop_front();
        rename(4, 4, 4); rel_valid = 1; rel_preg = x;
        step();
        idle(); rename(6, 6, 6);
        #1 chk("R9 ready kept", int'(rename_ready), 1);
        chk("R9 released next", int'(out_pdst), int'(x));
        step();

        // R8: flush overrides request and release
        y = pend.pop_front();
        rename(6, 6, 6); rel_valid = 1; rel_preg = y; flush = 1;
        step();
        idle();
        for (int i = 0; i < 8; i++) begin
            req_src1 = 3'(i);
            #1 chk("R8 identity", int'(out_psrc1), i);
            step();
        end
        rename(0, 0, 6);
        #1 chk("R8 head", int'(out_pdst), 8);
        chk("R8 ready", int'(rename_ready), 1);
        step();

        // pseudo-random sweep
        for (int c = 0; c < 4000; c++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            idle();
            req_valid = rng[0];
            req_src1 = rng[3:1]; req_src2 = rng[6:4]; req_dst = rng[9:7];
            if (rng[10] && pend.size() != 0) begin
                rel_valid = 1; rel_preg = pend.pop_front();
            end
            flush = (rng[16:11] == 6'd0);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule